// File: doc/BRIEF.md
# Private Peripheral Window Decoder

This block sits on a shared internal bus in front of five private register banks: coherency control, the CPU interrupt interface, the global timer, the per-CPU timer and watchdog, and the interrupt distributor. The window covers 8 KB and sits at a base that is set at run time. For each request, the block checks address bits [31:13] against that base. If they match, it finds the region that the low 13 bits address. It then applies that region's rules on access size, byte strobes, burst length and source port.

A legal request raises exactly one target select in the same cycle. The selected bank's read data is returned one cycle later with an OKAY response. A read of a byte returns only the addressed lane. An illegal request raises no select at all, so it cannot cause a write side effect. It gets a slave-error response one cycle later, with zero data. A request outside the window is left alone: no select and no response, so another slave can claim it.

Top module: `privwin_dec`

## Requirements
- R1: The window is claimed (`win_hit_o`=1) only when `req_addr_i[31:13]` equals `base_i`. For an unclaimed request, no select is raised and no response follows on the next cycle.
- R2: Window offset bit 12 set selects the distributor (`tgt_sel_o[4]`). Otherwise `offset[11:8]` selects as follows: 0 is coherency control (bit 0), 1 is the CPU interface (bit 1), 2 is the global timer (bit 2) and 6 is the private timer/watchdog (bit 3). The select is combinational in the request cycle, and at most one bit is ever set.
- R3: With bit 12 clear, `offset[11:8]` from 7 to 15 is reserved. Any request to those offsets gets a slave error.
- R4: With bit 12 clear, `offset[11:8]` from 3 to 5 is unimplemented. A request that passes the size, strobe, burst and port rules gets an OKAY response with read data zero and raises no select.
- R5: Size encoding is 0=byte, 1=halfword, 2=word, 3=doubleword. Halfword and doubleword requests always get a slave error.
- R6: The global timer and private timer regions accept word requests only. A byte request to them gets a slave error.
- R7: A word request whose `req_strb_i` is not 4'b1111 gets a slave error.
- R8: A request with `req_len_i` (beats minus one) not zero gets a slave error.
- R9: A request with `req_from_acp_i`=1 gets a slave error.
- R10: A claimed request is answered on the next clock edge with `resp_valid_o`=1. `resp_err_o` is high if and only if the request was rejected, and a rejected request has no select raised.
- R11: A read response carries the selected bank's data. For a byte read, only the lane `addr[1:0]` is kept (bits 8*lane+7 down to 8*lane) and the other lanes are zero. Error responses and write responses carry zero data.
- R12: While reset is asserted, and until it has been released, `resp_valid_o` and `resp_err_o` are 0 and `resp_rdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_i | input | 19 | Window base, compared with address bits [31:13] |
| req_valid_i | input | 1 | Request present this cycle |
| req_addr_i | input | 32 | Byte address |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| req_strb_i | input | 4 | Byte strobes |
| req_len_i | input | 4 | Beats minus one |
| req_from_acp_i | input | 1 | Request came from the accelerator coherency port |
| tgt_rdata_i | input | 160 | Read data of the five banks, bank k at bits [32k+31:32k] |
| win_hit_o | output | 1 | Address lies in the window |
| tgt_sel_o | output | 5 | One-hot bank select for legal requests |
| resp_valid_o | output | 1 | Response to the previous cycle's claimed request |
| resp_err_o | output | 1 | Slave error response |
| resp_rdata_o | output | 32 | Response read data |

## Verification
A wrong region decode shows at the ports in the request cycle itself, as a wrong or extra bit in `tgt_sel_o`. A wrong legality decision shows in the same cycle, as a select raised for a request that should have been rejected. A fault in the response register or in the lane steering shows exactly one edge later, in `resp_err_o` or `resp_rdata_o`. The bench therefore checks the select before the edge and the response after it. It sweeps every 256-byte slot of the window, every byte lane, all four sizes and several strobe patterns, for reads and writes, and adds ACP and burst requests and addresses outside the window.

// File: rtl/privwin_pkg.sv
package privwin_pkg;
  typedef enum logic [2:0] {
    RG_COH   = 3'd0,
    RG_CPUIF = 3'd1,
    RG_GTIM  = 3'd2,
    RG_PTIM  = 3'd3,
    RG_DIST  = 3'd4,
    RG_HOLE  = 3'd5,
    RG_RESV  = 3'd6
  } region_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } size_e;

  localparam int unsigned N_TGT = 5;
endpackage

// File: rtl/privwin_region_map.sv
module privwin_region_map
  import privwin_pkg::*;
#(
  parameter int unsigned PAGE_BITS = 13
) (
  input  logic [PAGE_BITS-1:0] offset_i,
  output region_e              region_o
);
  localparam int unsigned SLOT_LSB = 8;

  logic [3:0] slot;

  always_comb begin
    slot = offset_i[SLOT_LSB+3:SLOT_LSB];
    if (offset_i[PAGE_BITS-1]) begin
      region_o = RG_DIST;
    end else begin
      case (slot)
        4'd0:                region_o = RG_COH;
        4'd1:                region_o = RG_CPUIF;
        4'd2:                region_o = RG_GTIM;
        4'd3, 4'd4, 4'd5:    region_o = RG_HOLE;
        4'd6:                region_o = RG_PTIM;
        default:             region_o = RG_RESV;
      endcase
    end
  end
endmodule

// File: rtl/privwin_rule_chk.sv
module privwin_rule_chk
  import privwin_pkg::*;
#(
  parameter int unsigned LANES = 4,
  parameter int unsigned LEN_W = 4
) (
  input  region_e          region_i,
  input  logic [1:0]       size_i,
  input  logic [LANES-1:0] strb_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             from_acp_i,
  output logic             reject_o
);
  logic word_only;
  logic size_bad;
  logic strb_bad;

  always_comb begin
    word_only = (region_i == RG_GTIM) || (region_i == RG_PTIM);
    size_bad  = (size_i == SZ_HALF) || (size_i == SZ_DBL) ||
                (word_only && (size_i != SZ_WORD));
    strb_bad  = (size_i == SZ_WORD) && (strb_i != {LANES{1'b1}});
    reject_o  = from_acp_i || (len_i != '0) || (region_i == RG_RESV) ||
                size_bad || strb_bad;
  end
endmodule

// File: rtl/privwin_resp.sv
module privwin_resp
  import privwin_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N      = N_TGT
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                claim_i,
  input  logic                reject_i,
  input  logic                write_i,
  input  logic                byte_i,
  input  logic [1:0]          lane_i,
  input  logic [N-1:0]        sel_i,
  input  logic [N*DATA_W-1:0] rdata_i,
  output logic                valid_o,
  output logic                err_o,
  output logic [DATA_W-1:0]   rdata_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [N*DATA_W-1:0] cand;
  logic [DATA_W-1:0] muxed;
  logic [DATA_W-1:0] lane_mask;
  logic              valid_d, err_d;
  logic [DATA_W-1:0] rdata_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  for (genvar g = 0; g < N; g++) begin : g_cand
    assign cand[g*DATA_W +: DATA_W] = sel_i[g] ? rdata_i[g*DATA_W +: DATA_W] : '0;
  end

  always_comb begin
    muxed = '0;
    for (int k = 0; k < N; k++) muxed = muxed | cand[k*DATA_W +: DATA_W];
    lane_mask = byte_i ? ({{(DATA_W-8){1'b0}}, 8'hFF} << (8 * lane_i)) : '1;
    valid_d   = claim_i;
    err_d     = claim_i && reject_i;
    rdata_d   = (claim_i && !reject_i && !write_i) ? (muxed & lane_mask) : '0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      valid_o <= valid_d;
      err_o   <= err_d;
      rdata_o <= rdata_d;
    end
  end
endmodule

// File: rtl/privwin_dec.sv
module privwin_dec
  import privwin_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned PAGE_BITS = 13,
  parameter int unsigned LEN_W     = 4,
  localparam int unsigned BASE_W   = ADDR_W - PAGE_BITS,
  localparam int unsigned LANES    = DATA_W / 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [BASE_W-1:0]       base_i,
  input  logic                    req_valid_i,
  input  logic [ADDR_W-1:0]       req_addr_i,
  input  logic                    req_write_i,
  input  logic [1:0]              req_size_i,
  input  logic [LANES-1:0]        req_strb_i,
  input  logic [LEN_W-1:0]        req_len_i,
  input  logic                    req_from_acp_i,
  input  logic [N_TGT*DATA_W-1:0] tgt_rdata_i,
  output logic                    win_hit_o,
  output logic [N_TGT-1:0]        tgt_sel_o,
  output logic                    resp_valid_o,
  output logic                    resp_err_o,
  output logic [DATA_W-1:0]       resp_rdata_o
);
  region_e region;
  logic    reject;
  logic    claim;

  assign win_hit_o = (req_addr_i[ADDR_W-1:PAGE_BITS] == base_i);
  assign claim     = req_valid_i && win_hit_o;

  privwin_region_map #(.PAGE_BITS(PAGE_BITS)) u_map (
    .offset_i (req_addr_i[PAGE_BITS-1:0]),
    .region_o (region)
  );

  privwin_rule_chk #(.LANES(LANES), .LEN_W(LEN_W)) u_rule (
    .region_i   (region),
    .size_i     (req_size_i),
    .strb_i     (req_strb_i),
    .len_i      (req_len_i),
    .from_acp_i (req_from_acp_i),
    .reject_o   (reject)
  );

  always_comb begin
    tgt_sel_o = '0;
    if (claim && !reject && (region < RG_HOLE)) tgt_sel_o[region] = 1'b1;
  end

  privwin_resp #(.DATA_W(DATA_W), .N(N_TGT)) u_resp (
    .clk      (clk),
    .rst_n    (rst_n),
    .claim_i  (claim),
    .reject_i (reject),
    .write_i  (req_write_i),
    .byte_i   (req_size_i == SZ_BYTE),
    .lane_i   (req_addr_i[1:0]),
    .sel_i    (tgt_sel_o),
    .rdata_i  (tgt_rdata_i),
    .valid_o  (resp_valid_o),
    .err_o    (resp_err_o),
    .rdata_o  (resp_rdata_o)
  );
endmodule

// File: rtl/privwin_chk.sv
module privwin_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid_i,
  input logic [3:0]  req_len_i,
  input logic        req_from_acp_i,
  input logic        win_hit_o,
  input logic [4:0]  tgt_sel_o,
  input logic        resp_valid_o,
  input logic        resp_err_o,
  input logic [31:0] resp_rdata_o
);
  // R2
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tgt_sel_o));
  // R1
  no_claim_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(req_valid_i && win_hit_o)) |=> !resp_valid_o);
  // R1
  sel_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_sel_o != 5'd0) |-> (req_valid_i && win_hit_o));
  // R10
  sel_then_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_sel_o != 5'd0 && $past(rst_n)) |=> (resp_valid_o && !resp_err_o));
  // R9
  acp_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_from_acp_i |-> (tgt_sel_o == 5'd0));
  // R8
  burst_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_len_i != 4'd0) |-> (tgt_sel_o == 5'd0));
  // R11
  err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_err_o |-> (resp_rdata_o == 32'd0));
endmodule

bind privwin_dec privwin_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid_i    (req_valid_i),
  .req_len_i      (req_len_i),
  .req_from_acp_i (req_from_acp_i),
  .win_hit_o      (win_hit_o),
  .tgt_sel_o      (tgt_sel_o),
  .resp_valid_o   (resp_valid_o),
  .resp_err_o     (resp_err_o),
  .resp_rdata_o   (resp_rdata_o)
);

// File: tb/sim_privwin_dec.sv
module sim_privwin_dec;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [18:0]  base_i;
  logic         req_valid_i, req_write_i, req_from_acp_i;
  logic [31:0]  req_addr_i;
  logic [1:0]   req_size_i;
  logic [3:0]   req_strb_i, req_len_i;
  logic [159:0] tgt_rdata_i;
  logic         win_hit_o, resp_valid_o, resp_err_o;
  logic [4:0]   tgt_sel_o;
  logic [31:0]  resp_rdata_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  privwin_dec u0 (.*);

  localparam logic [18:0] BASE = 19'h2_A5C3;

  function automatic logic [31:0] pat(int k);
    return {8'hA0 + 8'(k), 8'hB0 + 8'(k), 8'hC0 + 8'(k), 8'hD0 + 8'(k)};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // region code: 0..4 banks, 5 hole, 6 reserved
  function automatic int reg_of(logic [12:0] off);
    int s;
    s = int'(off[11:8]);
    if (off[12]) return 4;
    if (s == 0) return 0;
    if (s == 1) return 1;
    if (s == 2) return 2;
    if (s == 6) return 3;
    if (s >= 3 && s <= 5) return 5;
    return 6;
  endfunction

  task automatic do_req(logic [31:0] addr, bit wr, logic [1:0] sz, logic [3:0] strb,
                        logic [3:0] len, bit acp);
    bit hit, rej;
    int rg;
    logic [4:0]  esel;
    logic [31:0] edat;
    req_valid_i = 1'b1; req_addr_i = addr; req_write_i = wr; req_size_i = sz;
    req_strb_i = strb; req_len_i = len; req_from_acp_i = acp;
    hit = (addr[31:13] == base_i);
    rg  = reg_of(addr[12:0]);
    rej = acp || (len != 0) || (rg == 6) || (sz == 2'd1) || (sz == 2'd3) ||
          ((rg == 2 || rg == 3) && sz != 2'd2) || (sz == 2'd2 && strb != 4'hF);
    esel = (hit && !rej && rg < 5) ? 5'(1 << rg) : 5'd0;
    edat = 32'd0;
    if (hit && !rej && !wr && rg < 5)
      edat = (sz == 2'd0) ? (pat(rg) & (32'hFF << (8 * addr[1:0]))) : pat(rg);
    #1;
    chk(hit ? "R2 select" : "R1 select", {27'd0, tgt_sel_o}, {27'd0, esel});
    chk("R1 hit", {31'd0, win_hit_o}, {31'd0, hit});
    @(posedge clk); @(negedge clk);
    chk("R10 valid", {31'd0, resp_valid_o}, {31'd0, hit});
    chk(rg == 6 ? "R3 err" : (acp ? "R9 err" : (len != 0 ? "R8 err" :
        (sz == 2'd1 || sz == 2'd3 ? "R5 err" : ((rg == 2 || rg == 3) ? "R6 err" :
        "R7 err")))), {31'd0, resp_err_o}, {31'd0, hit && rej});
    chk(rg == 5 ? "R4 data" : "R11 data", resp_rdata_o, edat);
  endtask

  initial begin
    for (int k = 0; k < 5; k++) tgt_rdata_i[k*32 +: 32] = pat(k);
    base_i = BASE; rst_n = 1'b0; req_valid_i = 1'b0; req_addr_i = '0;
    req_write_i = 1'b0; req_size_i = 2'd2; req_strb_i = 4'hF; req_len_i = '0;
    req_from_acp_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 valid", {31'd0, resp_valid_o}, 32'd0);
    chk("R12 err", {31'd0, resp_err_o}, 32'd0);
    chk("R12 data", resp_rdata_o, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12 idle", {31'd0, resp_valid_o}, 32'd0);
    for (int slot = 0; slot < 32; slot++)
      for (int sz = 0; sz < 4; sz++)
        for (int wr = 0; wr < 2; wr++)
          for (int sb = 0; sb < 3; sb++)
            for (int ln = 0; ln < 4; ln++) begin
              logic [3:0] st;
              st = (sb == 0) ? 4'hF : ((sb == 1) ? 4'h1 : 4'h7);
              if (sz != 0 && ln != 0) continue;
              do_req({BASE, 13'(slot * 256 + 4 + ln)}, wr[0], sz[1:0], st, 4'd0, 1'b0);
            end
    for (int slot = 0; slot < 32; slot += 3) begin
      do_req({BASE, 13'(slot * 256)}, 1'b0, 2'd2, 4'hF, 4'd0, 1'b1);  // R9
      do_req({BASE, 13'(slot * 256)}, 1'b1, 2'd2, 4'hF, 4'd3, 1'b0);  // R8
      do_req({BASE, 13'(slot * 256)}, 1'b0, 2'd0, 4'h1, 4'd1, 1'b0);  // R8
    end
    do_req({BASE + 19'd1, 13'h0200}, 1'b0, 2'd2, 4'hF, 4'd0, 1'b0);  // R1
    do_req({BASE - 19'd1, 13'h1FFC}, 1'b1, 2'd1, 4'h3, 4'd2, 1'b1);  // R1
    base_i = BASE ^ 19'h4_0001;
    do_req({BASE ^ 19'h4_0001, 13'h0600}, 1'b0, 2'd2, 4'hF, 4'd0, 1'b0);  // R1 moved base
    do_req({BASE, 13'h0600}, 1'b0, 2'd2, 4'hF, 4'd0, 1'b0);  // R1 old base unclaimed
    req_valid_i = 1'b0;
    @(negedge clk);
    chk("R1 idle", {31'd0, resp_valid_o}, 32'd0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule